// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the software-visible control and status state of a multi-channel DMA layer that serves a set of transmit channels and a set of receive channels. Software reaches it over a simple register bus: each access carries a register number, a write flag and 32 bits of write data. Reads return data combinationally in the same cycle. The block holds the following registers:

- a global configuration word, which includes a self-clearing soft-reset command;
- an interrupt enable word and an error status word;
- active-set and active-reset words for each direction;
- four per-channel interrupt status vectors (end-of-buffer and descriptor-error, for transmit and for receive);
- one descriptor table pointer per channel;
- one buffer size per receive channel.

A downstream DMA engine reads the stored values from flat output buses. It reports events back through one-cycle set pulses, which raise the matching status bits. Software clears a status bit by writing a one to it. Four interrupt lines each summarise one enabled status group. The channel counts are parameters of at most 32 each. A register number that lies past the configured count in a per-channel range addresses nothing.

Top module: `dma_ctl_regfile`

## Requirements
- R1: After reset the configuration word reads 0x0007C000. Every other register and every interrupt line is zero.
- R2: A write to the configuration word (number 0x180) with bit 31 clear stores the write data ANDed with 0x00FFC087.
- R3: A write to the configuration word with bit 31 set returns every register of the block to its R1 value at that clock edge. This includes the pointers, the buffer sizes and the status vectors. Set pulses arriving in the same cycle are dropped.
- R4: Masking on write:
  - interrupt enable (0x182) keeps bits 4:0;
  - transmit active set and reset (0x184, 0x185) keep bits 31:28;
  - receive active set and reset (0x190, 0x191) keep bits 31:30.
- R5: The status registers clear by writing a one. Writing a one clears that bit and writing a zero leaves it. The registers are:
  - error status (0x181);
  - transmit end-of-buffer (0x186) and transmit descriptor-error (0x187);
  - receive end-of-buffer (0x192) and receive descriptor-error (0x193).
  Channel n sits at bit n and the upper bits read zero.
- R6: A set pulse on a channel, or on a bit of the error set input, makes the matching status bit one after the next clock edge. If a set and a software clear hit the same bit in one cycle, the set wins.
- R7: Transmit pointer n sits at 0x1A0+n and receive pointer n at 0x1C0+n. Each keeps all 32 bits and appears on lane n (bits 32n+31:32n) of its flat output.
- R8: Receive buffer size n sits at 0x1E0+n and keeps bits 7:0. It appears on lane n (bits 8n+7:8n) of the buffer size output.
- R9: Accesses that address nothing read zero and change no state. This covers a number in a per-channel range at or beyond the channel count, and any number outside the map.
- R10: Each interrupt line is the OR of one status vector ANDed with one enable bit:
  - irqOut[0] is transmit end-of-buffer with enable bit 0;
  - irqOut[1] is receive end-of-buffer with enable bit 1;
  - irqOut[2] is transmit descriptor-error with enable bit 2;
  - irqOut[3] is receive descriptor-error with enable bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Register access valid this cycle |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Register number |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle |
| txEobSet | input | TX_CH | Transmit end-of-buffer set pulses |
| txDerrSet | input | TX_CH | Transmit descriptor-error set pulses |
| rxEobSet | input | RX_CH | Receive end-of-buffer set pulses |
| rxDerrSet | input | RX_CH | Receive descriptor-error set pulses |
| errSet | input | 32 | Error status set pulses |
| cfgQ | output | 32 | Stored configuration word |
| txActSetQ | output | 32 | Stored transmit active-set word |
| txActRstQ | output | 32 | Stored transmit active-reset word |
| rxActSetQ | output | 32 | Stored receive active-set word |
| rxActRstQ | output | 32 | Stored receive active-reset word |
| txPtrFlat | output | TX_CH*32 | Transmit descriptor pointers, one lane per channel |
| rxPtrFlat | output | RX_CH*32 | Receive descriptor pointers, one lane per channel |
| rxBufSizeFlat | output | RX_CH*8 | Receive buffer sizes, one lane per channel |
| irqOut | output | 4 | Interrupt lines |

## Verification
The properties assume a bus that never raises regSel while the reset is asserted. They also assume that the set-wins check only matters for cycles that are not a soft-reset write, because a soft reset deliberately drops set pulses. The stimulus drives every access and pulse on the falling edge and holds it for exactly one cycle. It only raises set pulses on channels that exist. It issues the soft-reset write once, after all other state has been loaded, so that its clearing effect can be seen on every register.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int REG_W = 32;
  localparam int MAX_CH = 32;
  localparam int CH_W = 5;

  localparam logic [31:0] CFG_RST = 32'h0007_C000;
  localparam logic [31:0] CFG_MASK = 32'h00FF_C087;
  localparam logic [31:0] IEN_MASK = 32'h0000_001F;
  localparam logic [31:0] TXACT_MASK = 32'hF000_0000;
  localparam logic [31:0] RXACT_MASK = 32'hC000_0000;
  localparam logic [7:0] BSZ_MASK = 8'hFF;

  // register numbers
  localparam int A_CFG = 'h180;
  localparam int A_ERR = 'h181;
  localparam int A_IEN = 'h182;
  localparam int A_TXSET = 'h184;
  localparam int A_TXRST = 'h185;
  localparam int A_TXEOB = 'h186;
  localparam int A_TXDERR = 'h187;
  localparam int A_RXSET = 'h190;
  localparam int A_RXRST = 'h191;
  localparam int A_RXEOB = 'h192;
  localparam int A_RXDERR = 'h193;
  localparam int A_TXPTR = 'h1A0;
  localparam int A_RXPTR = 'h1C0;
  localparam int A_RXBSZ = 'h1E0;

  typedef enum logic [3:0] {
    K_NONE, K_CFG, K_ERR, K_IEN, K_TXSET, K_TXRST, K_TXEOB, K_TXDERR,
    K_RXSET, K_RXRST, K_RXEOB, K_RXDERR, K_TXPTR, K_RXPTR, K_RXBSZ
  } regKind_e;

  // strobes from decode to storage
  typedef struct packed {
    logic wr;
    logic rd;
    logic softRst;
    regKind_e kind;
    logic [CH_W-1:0] chan;
  } regStrobe_t;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TX_CH = 4,
  parameter int RX_CH = 2
) (
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wdataTop,
  output regStrobe_t        strb
);
  regKind_e kind;
  logic [CH_W-1:0] chan;

  always_comb begin
    kind = K_NONE;
    chan = '0;
    if (regAddr == ADDR_W'(A_CFG)) kind = K_CFG;
    else if (regAddr == ADDR_W'(A_ERR)) kind = K_ERR;
    else if (regAddr == ADDR_W'(A_IEN)) kind = K_IEN;
    else if (regAddr == ADDR_W'(A_TXSET)) kind = K_TXSET;
    else if (regAddr == ADDR_W'(A_TXRST)) kind = K_TXRST;
    else if (regAddr == ADDR_W'(A_TXEOB)) kind = K_TXEOB;
    else if (regAddr == ADDR_W'(A_TXDERR)) kind = K_TXDERR;
    else if (regAddr == ADDR_W'(A_RXSET)) kind = K_RXSET;
    else if (regAddr == ADDR_W'(A_RXRST)) kind = K_RXRST;
    else if (regAddr == ADDR_W'(A_RXEOB)) kind = K_RXEOB;
    else if (regAddr == ADDR_W'(A_RXDERR)) kind = K_RXDERR;
    else if (regAddr >= ADDR_W'(A_TXPTR) && regAddr < ADDR_W'(A_TXPTR + TX_CH)) begin
      kind = K_TXPTR;
      chan = CH_W'(regAddr - ADDR_W'(A_TXPTR));
    end else if (regAddr >= ADDR_W'(A_RXPTR) && regAddr < ADDR_W'(A_RXPTR + RX_CH)) begin
      kind = K_RXPTR;
      chan = CH_W'(regAddr - ADDR_W'(A_RXPTR));
    end else if (regAddr >= ADDR_W'(A_RXBSZ) && regAddr < ADDR_W'(A_RXBSZ + RX_CH)) begin
      kind = K_RXBSZ;
      chan = CH_W'(regAddr - ADDR_W'(A_RXBSZ));
    end
  end

  always_comb begin
    strb.kind = kind;
    strb.chan = chan;
    strb.wr = regSel && regWr && (kind != K_NONE);
    strb.rd = regSel && !regWr;
    strb.softRst = strb.wr && (kind == K_CFG) && wdataTop;
  end
endmodule

// File: rtl/dmareg_store.sv
module dmareg_store
  import dmareg_pkg::*;
#(
  parameter int TX_CH = 4,  // at most MAX_CH
  parameter int RX_CH = 2   // at most MAX_CH
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strb,
  input  logic [REG_W-1:0]       regWdata,
  input  logic [TX_CH-1:0]       txEobSet,
  input  logic [TX_CH-1:0]       txDerrSet,
  input  logic [RX_CH-1:0]       rxEobSet,
  input  logic [RX_CH-1:0]       rxDerrSet,
  input  logic [REG_W-1:0]       errSet,
  output logic [REG_W-1:0]       regRdata,
  output logic [REG_W-1:0]       cfgQ,
  output logic [REG_W-1:0]       ienQ,
  output logic [REG_W-1:0]       txActSetQ,
  output logic [REG_W-1:0]       txActRstQ,
  output logic [REG_W-1:0]       rxActSetQ,
  output logic [REG_W-1:0]       rxActRstQ,
  output logic [TX_CH-1:0]       txEobStat,
  output logic [TX_CH-1:0]       txDerrStat,
  output logic [RX_CH-1:0]       rxEobStat,
  output logic [RX_CH-1:0]       rxDerrStat,
  output logic [TX_CH*REG_W-1:0] txPtrFlat,
  output logic [RX_CH*REG_W-1:0] rxPtrFlat,
  output logic [RX_CH*8-1:0]     rxBufSizeFlat
);
  logic [REG_W-1:0] cfgR, ienR, errR, txSetR, txRstR, rxSetR, rxRstR;
  logic [REG_W-1:0] cfgN, ienN, errN, txSetN, txRstN, rxSetN, rxRstN;
  logic [TX_CH-1:0] txEobR, txDerrR, txEobN, txDerrN;
  logic [RX_CH-1:0] rxEobR, rxDerrR, rxEobN, rxDerrN;
  logic [REG_W-1:0] txPtrR [TX_CH];
  logic [REG_W-1:0] rxPtrR [RX_CH];
  logic [7:0] rxBszR [RX_CH];
  regKind_e wrKind;

  // next state of the scalar and status registers
  always_comb begin
    wrKind = strb.wr ? strb.kind : K_NONE;
    cfgN = cfgR;
    ienN = ienR;
    txSetN = txSetR;
    txRstN = txRstR;
    rxSetN = rxSetR;
    rxRstN = rxRstR;
    case (wrKind)
      K_CFG: cfgN = regWdata & CFG_MASK;
      K_IEN: ienN = regWdata & IEN_MASK;
      K_TXSET: txSetN = regWdata & TXACT_MASK;
      K_TXRST: txRstN = regWdata & TXACT_MASK;
      K_RXSET: rxSetN = regWdata & RXACT_MASK;
      K_RXRST: rxRstN = regWdata & RXACT_MASK;
      default: ;
    endcase
    // clear by one, then set pulses on top so the set wins
    errN = (errR & ~((wrKind == K_ERR) ? regWdata : '0)) | errSet;
    txEobN = (txEobR & ~((wrKind == K_TXEOB) ? regWdata[TX_CH-1:0] : '0)) | txEobSet;
    txDerrN = (txDerrR & ~((wrKind == K_TXDERR) ? regWdata[TX_CH-1:0] : '0)) | txDerrSet;
    rxEobN = (rxEobR & ~((wrKind == K_RXEOB) ? regWdata[RX_CH-1:0] : '0)) | rxEobSet;
    rxDerrN = (rxDerrR & ~((wrKind == K_RXDERR) ? regWdata[RX_CH-1:0] : '0)) | rxDerrSet;
    if (strb.softRst) begin
      cfgN = CFG_RST;
      ienN = '0;
      errN = '0;
      txSetN = '0;
      txRstN = '0;
      rxSetN = '0;
      rxRstN = '0;
      txEobN = '0;
      txDerrN = '0;
      rxEobN = '0;
      rxDerrN = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgR <= CFG_RST;
      ienR <= '0;
      errR <= '0;
      txSetR <= '0;
      txRstR <= '0;
      rxSetR <= '0;
      rxRstR <= '0;
      txEobR <= '0;
      txDerrR <= '0;
      rxEobR <= '0;
      rxDerrR <= '0;
    end else begin
      cfgR <= cfgN;
      ienR <= ienN;
      errR <= errN;
      txSetR <= txSetN;
      txRstR <= txRstN;
      rxSetR <= rxSetN;
      rxRstR <= rxRstN;
      txEobR <= txEobN;
      txDerrR <= txDerrN;
      rxEobR <= rxEobN;
      rxDerrR <= rxDerrN;
    end
  end

  // per-channel arrays
  for (genvar c = 0; c < TX_CH; c++) begin : g_txch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) txPtrR[c] <= '0;
      else if (strb.softRst) txPtrR[c] <= '0;
      else if (wrKind == K_TXPTR && strb.chan == CH_W'(c)) txPtrR[c] <= regWdata;
    end
    assign txPtrFlat[c*REG_W +: REG_W] = txPtrR[c];
  end

  for (genvar c = 0; c < RX_CH; c++) begin : g_rxch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxPtrR[c] <= '0;
        rxBszR[c] <= '0;
      end else if (strb.softRst) begin
        rxPtrR[c] <= '0;
        rxBszR[c] <= '0;
      end else begin
        if (wrKind == K_RXPTR && strb.chan == CH_W'(c)) rxPtrR[c] <= regWdata;
        if (wrKind == K_RXBSZ && strb.chan == CH_W'(c)) rxBszR[c] <= regWdata[7:0] & BSZ_MASK;
      end
    end
    assign rxPtrFlat[c*REG_W +: REG_W] = rxPtrR[c];
    assign rxBufSizeFlat[c*8 +: 8] = rxBszR[c];
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (strb.rd) begin
      case (strb.kind)
        K_CFG: regRdata = cfgR;
        K_ERR: regRdata = errR;
        K_IEN: regRdata = ienR;
        K_TXSET: regRdata = txSetR;
        K_TXRST: regRdata = txRstR;
        K_RXSET: regRdata = rxSetR;
        K_RXRST: regRdata = rxRstR;
        K_TXEOB: regRdata = REG_W'(txEobR);
        K_TXDERR: regRdata = REG_W'(txDerrR);
        K_RXEOB: regRdata = REG_W'(rxEobR);
        K_RXDERR: regRdata = REG_W'(rxDerrR);
        K_TXPTR:
          for (int i = 0; i < TX_CH; i++)
            if (strb.chan == CH_W'(i)) regRdata = txPtrR[i];
        K_RXPTR:
          for (int i = 0; i < RX_CH; i++)
            if (strb.chan == CH_W'(i)) regRdata = rxPtrR[i];
        K_RXBSZ:
          for (int i = 0; i < RX_CH; i++)
            if (strb.chan == CH_W'(i)) regRdata = REG_W'(rxBszR[i]);
        default: regRdata = '0;
      endcase
    end
  end

  assign cfgQ = cfgR;
  assign ienQ = ienR;
  assign txActSetQ = txSetR;
  assign txActRstQ = txRstR;
  assign rxActSetQ = rxSetR;
  assign rxActRstQ = rxRstR;
  assign txEobStat = txEobR;
  assign txDerrStat = txDerrR;
  assign rxEobStat = rxEobR;
  assign rxDerrStat = rxDerrR;
endmodule

// File: rtl/dma_ctl_regfile.sv
module dma_ctl_regfile
  import dmareg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TX_CH = 4,
  parameter int RX_CH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regSel,
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic [TX_CH-1:0]      txEobSet,
  input  logic [TX_CH-1:0]      txDerrSet,
  input  logic [RX_CH-1:0]      rxEobSet,
  input  logic [RX_CH-1:0]      rxDerrSet,
  input  logic [31:0]           errSet,
  output logic [31:0]           cfgQ,
  output logic [31:0]           txActSetQ,
  output logic [31:0]           txActRstQ,
  output logic [31:0]           rxActSetQ,
  output logic [31:0]           rxActRstQ,
  output logic [TX_CH*32-1:0]   txPtrFlat,
  output logic [RX_CH*32-1:0]   rxPtrFlat,
  output logic [RX_CH*8-1:0]    rxBufSizeFlat,
  output logic [3:0]            irqOut
);
  regStrobe_t strb;
  logic [31:0] ienQ;
  logic [TX_CH-1:0] txEobStat, txDerrStat;
  logic [RX_CH-1:0] rxEobStat, rxDerrStat;

  dmareg_decode #(.ADDR_W(ADDR_W), .TX_CH(TX_CH), .RX_CH(RX_CH)) u_decode (
    .regSel(regSel),
    .regWr(regWr),
    .regAddr(regAddr),
    .wdataTop(regWdata[31]),
    .strb(strb)
  );

  dmareg_store #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_store (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .regWdata(regWdata),
    .txEobSet(txEobSet),
    .txDerrSet(txDerrSet),
    .rxEobSet(rxEobSet),
    .rxDerrSet(rxDerrSet),
    .errSet(errSet),
    .regRdata(regRdata),
    .cfgQ(cfgQ),
    .ienQ(ienQ),
    .txActSetQ(txActSetQ),
    .txActRstQ(txActRstQ),
    .rxActSetQ(rxActSetQ),
    .rxActRstQ(rxActRstQ),
    .txEobStat(txEobStat),
    .txDerrStat(txDerrStat),
    .rxEobStat(rxEobStat),
    .rxDerrStat(rxDerrStat),
    .txPtrFlat(txPtrFlat),
    .rxPtrFlat(rxPtrFlat),
    .rxBufSizeFlat(rxBufSizeFlat)
  );

  // one line per enabled status group
  assign irqOut[0] = ienQ[0] & (|txEobStat);
  assign irqOut[1] = ienQ[1] & (|rxEobStat);
  assign irqOut[2] = ienQ[2] & (|txDerrStat);
  assign irqOut[3] = ienQ[3] & (|rxDerrStat);
endmodule

// File: rtl/dmareg_checker.sv
module dmareg_checker #(
  parameter int ADDR_W = 10,
  parameter int TX_CH = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                regSel,
  input logic                regWr,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         regWdata,
  input logic [31:0]         regRdata,
  input logic [TX_CH-1:0]    txEobSet,
  input logic [31:0]         cfgQ,
  input logic [TX_CH*32-1:0] txPtrFlat,
  input logic [TX_CH-1:0]    txEobStat
);
  logic cfgWrite, softWrite, eobWrite, gapRead;
  assign cfgWrite = regSel && regWr && (regAddr == ADDR_W'('h180));
  assign softWrite = cfgWrite && regWdata[31];
  assign eobWrite = regSel && regWr && (regAddr == ADDR_W'('h186));
  assign gapRead = regSel && !regWr &&
                   (regAddr >= ADDR_W'('h1A0 + TX_CH)) && (regAddr < ADDR_W'('h1C0));

  // R3: soft reset restores the configuration, pointers and status
  a_r3_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    softWrite |=> (cfgQ == 32'h0007_C000 && txPtrFlat == '0 && txEobStat == '0));

  // R2: plain configuration write is masked
  a_r2_cfg_mask: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !regWdata[31]) |=> (cfgQ == ($past(regWdata) & 32'h00FF_C087)));

  // R6: a set pulse always lands, even against a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((|txEobSet) && !softWrite) |=> ((txEobStat & $past(txEobSet)) == $past(txEobSet)));

  // R5: writing ones clears those bits when no set competes
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (eobWrite && txEobSet == '0) |=> ((txEobStat & $past(regWdata[TX_CH-1:0])) == '0));

  // R9: pointer numbers past the channel count read zero
  a_r9_gap_read: assert property (@(posedge clk) disable iff (!rstN)
    gapRead |-> (regRdata == 32'h0));
endmodule

bind dma_ctl_regfile dmareg_checker #(.ADDR_W(ADDR_W), .TX_CH(TX_CH)) u_checker (
  .clk(clk),
  .rstN(rstN),
  .regSel(regSel),
  .regWr(regWr),
  .regAddr(regAddr),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .txEobSet(txEobSet),
  .cfgQ(cfgQ),
  .txPtrFlat(txPtrFlat),
  .txEobStat(txEobStat)
);

// File: tb/dma_ctl_regfile_bench.sv
module dma_ctl_regfile_bench;
  localparam int CLK_P = 10;
  localparam int TX_CH = 4;
  localparam int RX_CH = 2;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0;
  logic regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [TX_CH-1:0] txEobSet = '0, txDerrSet = '0;
  logic [RX_CH-1:0] rxEobSet = '0, rxDerrSet = '0;
  logic [31:0] errSet = '0;
  logic [31:0] cfgQ, txActSetQ, txActRstQ, rxActSetQ, rxActRstQ;
  logic [TX_CH*32-1:0] txPtrFlat;
  logic [RX_CH*32-1:0] rxPtrFlat;
  logic [RX_CH*8-1:0] rxBufSizeFlat;
  logic [3:0] irqOut;

  int nChecks = 0;
  int nErr = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_ctl_regfile #(.ADDR_W(ADDR_W), .TX_CH(TX_CH), .RX_CH(RX_CH)) u_dma_ctl_regfile (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .txEobSet(txEobSet), .txDerrSet(txDerrSet),
    .rxEobSet(rxEobSet), .rxDerrSet(rxDerrSet), .errSet(errSet), .cfgQ(cfgQ),
    .txActSetQ(txActSetQ), .txActRstQ(txActRstQ), .rxActSetQ(rxActSetQ),
    .rxActRstQ(rxActRstQ), .txPtrFlat(txPtrFlat), .rxPtrFlat(rxPtrFlat),
    .rxBufSizeFlat(rxBufSizeFlat), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [9:0] a;
    logic [31:0] w;
    logic [31:0] e;
    logic [3:0] r;
  } vec_t;

  // write then read back
  localparam vec_t VECS [17] = '{
    '{10'h180, 32'h1234_5678, 32'h0034_4000, 4'd2},  // R2
    '{10'h180, 32'h7FFF_FFFF, 32'h00FF_C087, 4'd2},  // R2
    '{10'h182, 32'hFFFF_FFFF, 32'h0000_001F, 4'd4},  // R4
    '{10'h184, 32'hFFFF_FFFF, 32'hF000_0000, 4'd4},  // R4
    '{10'h185, 32'h5A5A_5A5A, 32'h5000_0000, 4'd4},  // R4
    '{10'h190, 32'hFFFF_FFFF, 32'hC000_0000, 4'd4},  // R4
    '{10'h191, 32'h7FFF_FFFF, 32'h4000_0000, 4'd4},  // R4
    '{10'h1A0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd7},  // R7
    '{10'h1A3, 32'h0123_4567, 32'h0123_4567, 4'd7},  // R7
    '{10'h1A4, 32'hFFFF_FFFF, 32'h0000_0000, 4'd9},  // R9
    '{10'h1C1, 32'hCAFE_F00D, 32'hCAFE_F00D, 4'd7},  // R7
    '{10'h1C2, 32'h0000_0001, 32'h0000_0000, 4'd9},  // R9
    '{10'h1E0, 32'h0001_2345, 32'h0000_0045, 4'd8},  // R8
    '{10'h1E1, 32'hFFFF_FFFF, 32'h0000_00FF, 4'd8},  // R8
    '{10'h1E2, 32'h0000_00FF, 32'h0000_0000, 4'd9},  // R9
    '{10'h1FF, 32'h1111_1111, 32'h0000_0000, 4'd9},  // R9
    '{10'h183, 32'h2222_2222, 32'h0000_0000, 4'd9}   // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0;
  endtask

  task automatic regRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regSel = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    nErr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(10'h180, rd); check("R1 cfg", rd, 32'h0007_C000);
    regRead(10'h182, rd); check("R1 ien", rd, 32'h0);
    regRead(10'h186, rd); check("R1 txEob", rd, 32'h0);
    check("R1 irq", 32'(irqOut), 32'h0);
    check("R1 ptr", txPtrFlat[31:0], 32'h0);

    // table walk (R2 R4 R7 R8 R9)
    for (int i = 0; i < 17; i++) begin
      regWrite(VECS[i].a, VECS[i].w);
      regRead(VECS[i].a, rd);
      check($sformatf("R%0d vec%0d", VECS[i].r, i), rd, VECS[i].e);
    end

    // R7 R8 flat lanes, R4 outputs
    check("R7 txLane0", txPtrFlat[31:0], 32'hDEAD_BEEF);
    check("R7 txLane3", txPtrFlat[127:96], 32'h0123_4567);
    check("R7 rxLane1", rxPtrFlat[63:32], 32'hCAFE_F00D);
    check("R8 bszLanes", 32'(rxBufSizeFlat), 32'h0000_FF45);
    check("R4 txSetOut", txActSetQ, 32'hF000_0000);
    check("R2 cfgOut", cfgQ, 32'h00FF_C087);

    // R6 set pulses, R10 interrupt
    @(negedge clk); txEobSet = 4'b0101;
    @(negedge clk); txEobSet = '0;
    check("R10 irqTxEob", 32'(irqOut), 32'h1);
    regRead(10'h186, rd); check("R6 txEobSet", rd, 32'h5);

    // R5 clear one bit
    regWrite(10'h186, 32'h1);
    regRead(10'h186, rd); check("R5 w1c", rd, 32'h4);

    // R6 set wins against a clear of the same bit
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = 10'h186; regWdata = 32'hF; txEobSet = 4'b0010;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; txEobSet = '0;
    regRead(10'h186, rd); check("R6 setWins", rd, 32'h2);
    regWrite(10'h186, 32'h2);
    check("R10 irqDrop", 32'(irqOut), 32'h0);

    // R10 receive descriptor error, then masked by enable
    @(negedge clk); rxDerrSet = 2'b11;
    @(negedge clk); rxDerrSet = '0;
    check("R10 irqRxDerr", 32'(irqOut), 32'h8);
    regWrite(10'h182, 32'h7);
    check("R10 masked", 32'(irqOut), 32'h0);
    regRead(10'h193, rd); check("R6 rxDerr", rd, 32'h3);

    // R5 error status
    @(negedge clk); errSet = 32'h8000_0001;
    @(negedge clk); errSet = '0;
    regRead(10'h181, rd); check("R6 errSet", rd, 32'h8000_0001);
    regWrite(10'h181, 32'h8000_0000);
    regRead(10'h181, rd); check("R5 errClr", rd, 32'h1);

    // R3 soft reset with a competing set pulse
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = 10'h180; regWdata = 32'h8000_0000; txDerrSet = 4'b0001;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; txDerrSet = '0;
    regRead(10'h180, rd); check("R3 cfg", rd, 32'h0007_C000);
    regRead(10'h1A0, rd); check("R3 ptr", rd, 32'h0);
    regRead(10'h181, rd); check("R3 err", rd, 32'h0);
    regRead(10'h193, rd); check("R3 rxDerr", rd, 32'h0);
    regRead(10'h187, rd); check("R3 droppedSet", rd, 32'h0);
    regRead(10'h184, rd); check("R3 txSet", rd, 32'h0);
    check("R3 bsz", 32'(rxBufSizeFlat), 32'h0);

    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule